// File: doc/BRIEF.md
# Low-Frequency Clock Quality Monitor

This block judges the health of a slow (nominally 32 kHz) clock by timing it against a fast reference clock (nominally 48 MHz). The slow input is brought into the reference domain through a two-stage synchroniser. Every rising edge of the synchronised input ends one measurement. A measurement holds the number of reference cycles in the period, the number of those cycles during which the input was high, and how far that high time strays from half the period.

Software sets an inclusive window for the period and a ceiling for the duty variation, and chooses which checks are active. Each measurement then produces pass or fail events. A run of consecutive passing measurements counts towards a programmable threshold, at which point the clock is declared valid. If the clock later fails or stalls, an "unwell" event is raised. A stall is flagged when the period counter saturates before any edge arrives. Events are recorded in a sticky status register that software clears by writing ones. A per-bit enable mask selects which recorded events drive the interrupt line.

Top module: `clkmon_top`

## Requirements
- R1: After reset, the status, enable, control, limit and measured registers read zero, and `irq` is low.
- R2: When a synchronised rising edge follows an earlier rising edge with no clear or stall in between, the period register is set to the number of reference cycles between the two edges. The first rising edge after reset, a counter clear or a stall only arms the measurement and produces no result.
- R3: Each measurement stores two values. The high time is the number of reference cycles with the input high. The duty variation is |high − (period >> 1)|.
- R4: When control bit 0 is set, each measurement sets status bit 1 if min ≤ period ≤ max (inclusive). Otherwise it sets status bit 3 (fail).
- R5: When control bit 1 is set, each measurement sets status bit 2 if duty variation ≤ its maximum. Otherwise it sets status bit 3.
- R6: Every measurement sets status bit 0 (pulse ready), whatever the check enables are. A disabled check sets neither its pass bit nor the fail bit.
- R7: When control bit 2 is set, the valid count works as follows. It increments (saturating) on each measurement that passes all enabled checks. It resets to zero on a fail or a stall. Status bit 5 is set when the count first reaches the valid minimum, and the clock is then in the valid state. A fail or stall while in the valid state sets status bit 6 (unwell) and leaves the valid state.
- R8: If the period counter reaches its all-ones value (0xFFFF at the default width) with no rising edge, status bit 4 (stall) is set exactly once until the next edge.
- R9: Writing the status register clears each bit written as 1. An event that occurs in the same cycle as the write wins over the clear.
- R10: `irq` is high exactly when some status bit and the matching bit of the enable register are both 1.
- R11: Writing control bit 24 zeroes the counters, the measured registers and the valid count, and disarms the measurement. Bit 24 always reads back as 0.
- R12: The register word addresses are as follows. Measured values occupy the low bits.
  - 0: control, bits 2:0
  - 1: status, bits 6:0
  - 2: interrupt enable, bits 6:0
  - 3: period minimum
  - 4: period maximum
  - 5: duty-variation maximum
  - 6: valid minimum
  - 8: period (read only)
  - 9: high time (read only)
  - 10: duty variation (read only)
  - 11: valid count (read only)

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkIn32 | input | 1 | Slow clock under test, asynchronous to clk |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data (combinational from addr) |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
The hardest situation to reach from the ports is the unwell event. It needs an armed measurement, a run of passing periods long enough to cross the valid threshold, and only then a failing period. The stimulus therefore drives a single uninterrupted waveform. It first gives an arming edge and four in-window periods, and reads the valid count mid-stream. It then drives a short period and a trailing edge, so that the failure lands while the valid state is held. The stall case is reached by clearing the counters and holding the input low for slightly more than a full counter range.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] A_STATUS   = 4'd1;
  localparam logic [ADDR_W-1:0] A_IEN      = 4'd2;
  localparam logic [ADDR_W-1:0] A_PER_MIN  = 4'd3;
  localparam logic [ADDR_W-1:0] A_PER_MAX  = 4'd4;
  localparam logic [ADDR_W-1:0] A_DV_MAX   = 4'd5;
  localparam logic [ADDR_W-1:0] A_VAL_MIN  = 4'd6;
  localparam logic [ADDR_W-1:0] A_PERIOD   = 4'd8;
  localparam logic [ADDR_W-1:0] A_HIGH     = 4'd9;
  localparam logic [ADDR_W-1:0] A_DUTYVAR  = 4'd10;
  localparam logic [ADDR_W-1:0] A_VAL_CNT  = 4'd11;

  localparam int CLR_BIT = 24;
  localparam int NUM_EV  = 7;

  // strobes from datapath to control, valid for one reference cycle
  typedef struct packed {
    logic meas;    // armed rising edge: a measurement completes
    logic stall;   // period counter reaches saturation
    logic perOk;   // period inside window (meaningful with meas)
    logic dutyOk;  // duty variation under ceiling (meaningful with meas)
  } dpStb_t;
endpackage

// File: rtl/clkmon_datapath.sv
module clkmon_datapath
  import clkmon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkIn32,
  input  logic             clrCnt,
  input  logic [CNT_W-1:0] perMin,
  input  logic [CNT_W-1:0] perMax,
  input  logic [CNT_W-1:0] dvMax,
  output logic [CNT_W-1:0] periodQ,
  output logic [CNT_W-1:0] highQ,
  output logic [CNT_W-1:0] dutyVarQ,
  output dpStb_t           stb
);
  localparam logic [CNT_W-1:0] SAT = '1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [1:0]       syncQ;
  logic             prevQ;
  logic             armedQ;
  logic [CNT_W-1:0] perCnt;
  logic [CNT_W-1:0] hiCnt;
  logic [CNT_W-1:0] halfPer;
  logic [CNT_W-1:0] dvNow;
  logic             riseNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], clkIn32};
      prevQ <= syncQ[1];
    end
  end

  assign riseNow = syncQ[1] & ~prevQ;
  assign halfPer = perCnt >> 1;
  assign dvNow   = (hiCnt >= halfPer) ? (hiCnt - halfPer) : (halfPer - hiCnt);

  always_comb begin
    stb.meas   = riseNow && armedQ && !clrCnt;
    stb.stall  = !riseNow && !clrCnt && (perCnt == SAT - ONE);
    stb.perOk  = (perCnt >= perMin) && (perCnt <= perMax);
    stb.dutyOk = (dvNow <= dvMax);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perCnt   <= '0;
      hiCnt    <= '0;
      armedQ   <= 1'b0;
      periodQ  <= '0;
      highQ    <= '0;
      dutyVarQ <= '0;
    end else if (clrCnt) begin
      perCnt   <= '0;
      hiCnt    <= '0;
      armedQ   <= 1'b0;
      periodQ  <= '0;
      highQ    <= '0;
      dutyVarQ <= '0;
    end else begin
      if (riseNow) begin
        perCnt <= ONE;
        hiCnt  <= ONE;
        armedQ <= 1'b1;
      end else begin
        if (perCnt != SAT) perCnt <= perCnt + ONE;
        if (syncQ[1] && hiCnt != SAT) hiCnt <= hiCnt + ONE;
        if (stb.stall) armedQ <= 1'b0;
      end
      if (stb.meas) begin
        periodQ  <= perCnt;
        highQ    <= hiCnt;
        dutyVarQ <= dvNow;
      end
    end
  end
endmodule

// File: rtl/clkmon_ctrl.sv
module clkmon_ctrl
  import clkmon_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int VC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              irq,
  input  dpStb_t            stb,
  input  logic [CNT_W-1:0]  periodQ,
  input  logic [CNT_W-1:0]  highQ,
  input  logic [CNT_W-1:0]  dutyVarQ,
  output logic [CNT_W-1:0]  perMin,
  output logic [CNT_W-1:0]  perMax,
  output logic [CNT_W-1:0]  dvMax,
  output logic              clrCnt
);
  localparam logic [VC_W-1:0] VC_SAT = '1;

  logic [2:0]        chkEn;
  logic [NUM_EV-1:0] ienQ;
  logic [NUM_EV-1:0] statusQ;
  logic [NUM_EV-1:0] setVec;
  logic [NUM_EV-1:0] clrVec;
  logic [VC_W-1:0]   validMinQ;
  logic [VC_W-1:0]   validCntQ;
  logic [VC_W-1:0]   cntInc;
  logic              validStateQ;
  logic              failNow;
  logic              goodNow;
  logic              reachNow;
  logic              badNow;

  function automatic logic wrHit(input logic [ADDR_W-1:0] a);
    return wrEn && (addr == a);
  endfunction

  assign clrCnt  = wrHit(A_CTRL) && wrData[CLR_BIT];
  assign failNow = stb.meas && ((chkEn[0] && !stb.perOk) || (chkEn[1] && !stb.dutyOk));
  assign goodNow = stb.meas && !failNow;
  assign badNow  = failNow || stb.stall;
  assign cntInc  = (validCntQ == VC_SAT) ? validCntQ : validCntQ + VC_W'(1);
  assign reachNow = chkEn[2] && goodNow && !validStateQ && (cntInc >= validMinQ);

  always_comb begin
    setVec    = '0;
    setVec[0] = stb.meas;
    setVec[1] = stb.meas && chkEn[0] && stb.perOk;
    setVec[2] = stb.meas && chkEn[1] && stb.dutyOk;
    setVec[3] = failNow;
    setVec[4] = stb.stall;
    setVec[5] = reachNow;
    setVec[6] = validStateQ && badNow;
    clrVec    = wrHit(A_STATUS) ? wrData[NUM_EV-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkEn       <= '0;
      ienQ        <= '0;
      statusQ     <= '0;
      perMin      <= '0;
      perMax      <= '0;
      dvMax       <= '0;
      validMinQ   <= '0;
      validCntQ   <= '0;
      validStateQ <= 1'b0;
    end else begin
      if (wrHit(A_CTRL))    chkEn     <= wrData[2:0];
      if (wrHit(A_IEN))     ienQ      <= wrData[NUM_EV-1:0];
      if (wrHit(A_PER_MIN)) perMin    <= wrData[CNT_W-1:0];
      if (wrHit(A_PER_MAX)) perMax    <= wrData[CNT_W-1:0];
      if (wrHit(A_DV_MAX))  dvMax     <= wrData[CNT_W-1:0];
      if (wrHit(A_VAL_MIN)) validMinQ <= wrData[VC_W-1:0];
      statusQ <= (statusQ & ~clrVec) | setVec;

      if (clrCnt) begin
        validCntQ   <= '0;
        validStateQ <= 1'b0;
      end else begin
        if (chkEn[2]) begin
          if (badNow)       validCntQ <= '0;
          else if (goodNow) validCntQ <= cntInc;
        end
        if (badNow)        validStateQ <= 1'b0;
        else if (reachNow) validStateQ <= 1'b1;
      end
    end
  end

  assign irq = |(statusQ & ienQ);

  always_comb begin
    rdData = '0;
    unique case (addr)
      A_CTRL:    rdData[2:0]        = chkEn;
      A_STATUS:  rdData[NUM_EV-1:0] = statusQ;
      A_IEN:     rdData[NUM_EV-1:0] = ienQ;
      A_PER_MIN: rdData[CNT_W-1:0]  = perMin;
      A_PER_MAX: rdData[CNT_W-1:0]  = perMax;
      A_DV_MAX:  rdData[CNT_W-1:0]  = dvMax;
      A_VAL_MIN: rdData[VC_W-1:0]   = validMinQ;
      A_PERIOD:  rdData[CNT_W-1:0]  = periodQ;
      A_HIGH:    rdData[CNT_W-1:0]  = highQ;
      A_DUTYVAR: rdData[CNT_W-1:0]  = dutyVarQ;
      A_VAL_CNT: rdData[VC_W-1:0]   = validCntQ;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/clkmon_top.sv
module clkmon_top
  import clkmon_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int VC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkIn32,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              irq
);
  dpStb_t           stb;
  logic [CNT_W-1:0] periodQ;
  logic [CNT_W-1:0] highQ;
  logic [CNT_W-1:0] dutyVarQ;
  logic [CNT_W-1:0] perMin;
  logic [CNT_W-1:0] perMax;
  logic [CNT_W-1:0] dvMax;
  logic             clrCnt;

  clkmon_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .clkIn32(clkIn32), .clrCnt(clrCnt),
    .perMin(perMin), .perMax(perMax), .dvMax(dvMax),
    .periodQ(periodQ), .highQ(highQ), .dutyVarQ(dutyVarQ), .stb(stb)
  );

  clkmon_ctrl #(.CNT_W(CNT_W), .VC_W(VC_W)) ctl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq), .stb(stb),
    .periodQ(periodQ), .highQ(highQ), .dutyVarQ(dutyVarQ),
    .perMin(perMin), .perMax(perMax), .dvMax(dvMax), .clrCnt(clrCnt)
  );
endmodule

// File: rtl/clkmon_checker.sv
module clkmon_checker
  import clkmon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic              irq,
  input dpStb_t            stb,
  input logic              clrCnt,
  input logic [CNT_W-1:0]  periodQ,
  input logic [CNT_W-1:0]  highQ,
  input logic [CNT_W-1:0]  dutyVarQ
);
  // R8: an edge and a stall never coincide
  p_edge_or_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.meas, stb.stall}));

  // R8: the stall event is a single-cycle pulse
  p_stall_once_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.stall |=> !stb.stall);

  // R2: a clear disarms, so the following cycle yields no measurement
  p_clear_disarms_r2: assert property (@(posedge clk) disable iff (!rstN)
    clrCnt |=> !stb.meas);

  // R11: a clear zeroes the measured registers
  p_clear_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    clrCnt |=> (periodQ == '0 && highQ == '0 && dutyVarQ == '0));

  // R9/R10: clearing every status bit with no event pending drops the interrupt
  p_w1c_all_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_STATUS && wrData[NUM_EV-1:0] == '1 && !stb.meas && !stb.stall)
    |=> !irq);
endmodule

bind clkmon_top clkmon_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .irq(irq), .stb(stb), .clrCnt(clrCnt),
  .periodQ(periodQ), .highQ(highQ), .dutyVarQ(dutyVarQ)
);

// File: tb/clkmon_top_tb_top.sv
module clkmon_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  typedef struct packed {
    logic [15:0] per;
    logic [15:0] hi;
    logic [15:0] mn;
    logic [15:0] mx;
    logic [15:0] dv;
    logic [2:0]  en;
    logic [6:0]  st;
  } vec_t;

  // period, high, min, max, dvMax, check enables, expected status
  localparam vec_t VECS [NV] = '{
    '{16'd40, 16'd20, 16'd30, 16'd50, 16'd2, 3'b011, 7'h07},
    '{16'd60, 16'd30, 16'd30, 16'd50, 16'd2, 3'b011, 7'h0D},
    '{16'd40, 16'd30, 16'd30, 16'd50, 16'd2, 3'b011, 7'h0B},
    '{16'd30, 16'd15, 16'd30, 16'd30, 16'd2, 3'b011, 7'h07},
    '{16'd40, 16'd22, 16'd30, 16'd50, 16'd2, 3'b011, 7'h07},
    '{16'd50, 16'd25, 16'd30, 16'd50, 16'd2, 3'b011, 7'h07},
    '{16'd60, 16'd50, 16'd30, 16'd50, 16'd2, 3'b000, 7'h01},
    '{16'd29, 16'd14, 16'd30, 16'd50, 16'd2, 3'b001, 7'h09}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkIn32 = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkmon_top dut_i (
    .clk(clk), .rstN(rstN), .clkIn32(clkIn32), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic readReg(input logic [3:0] a, output int d);
    addr = a;
    #1;
    d = int'(rdData);
  endtask

  task automatic runPeriod(input int per, input int hi);
    clkIn32 = 1'b1;
    repeat (hi) @(negedge clk);
    clkIn32 = 1'b0;
    repeat (per - hi) @(negedge clk);
  endtask

  task automatic trailEdge();
    clkIn32 = 1'b1;
    repeat (3) @(negedge clk);
    clkIn32 = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      report();
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    readReg(4'd1, v);  check("R1 status", v, 0);
    readReg(4'd8, v);  check("R1 period", v, 0);
    readReg(4'd0, v);  check("R1 ctrl", v, 0);
    check("R1 irq", int'(irq), 0);

    // table walk: arm, three measured periods
    for (int i = 0; i < NV; i++) begin
      int expDv;
      writeReg(4'd3, 32'(VECS[i].mn));
      writeReg(4'd4, 32'(VECS[i].mx));
      writeReg(4'd5, 32'(VECS[i].dv));
      writeReg(4'd0, (32'd1 << 24) | 32'(VECS[i].en));
      writeReg(4'd1, 32'h7F);
      for (int k = 0; k < 3; k++) runPeriod(int'(VECS[i].per), int'(VECS[i].hi));
      trailEdge();
      expDv = int'(VECS[i].hi) - int'(VECS[i].per) / 2;
      if (expDv < 0) expDv = -expDv;
      readReg(4'd1, v);  check("R4/R5/R6 status", v, int'(VECS[i].st));
      readReg(4'd8, v);  check("R2 period", v, int'(VECS[i].per));
      readReg(4'd9, v);  check("R3 high", v, int'(VECS[i].hi));
      readReg(4'd10, v); check("R3 dutyvar", v, expDv);
    end

    // R12: limit readback at its own address
    readReg(4'd3, v); check("R12 permin", v, 30);

    // R10: irq follows enable mask (last vector: fail set, period pass clear)
    writeReg(4'd2, 32'h08);
    check("R10 irq on", int'(irq), 1);
    writeReg(4'd2, 32'h02);
    check("R10 irq off", int'(irq), 0);

    // R9: clear only the fail bit
    writeReg(4'd1, 32'h08);
    readReg(4'd1, v); check("R9 w1c", v, 32'h01);

    // R11: clear counters
    writeReg(4'd0, 32'h0100_0007);
    readReg(4'd8, v); check("R11 period", v, 0);
    readReg(4'd0, v); check("R11 ctrl", v, 7);

    // R7: valid run then failure
    writeReg(4'd3, 32'd30);
    writeReg(4'd4, 32'd50);
    writeReg(4'd5, 32'd5);
    writeReg(4'd6, 32'd3);
    writeReg(4'd0, 32'h0100_0007);
    writeReg(4'd1, 32'h7F);
    for (int k = 0; k < 4; k++) runPeriod(40, 20);
    readReg(4'd11, v); check("R7 count", v, 3);
    readReg(4'd1, v);  check("R7 valid", (v >> 5) & 3, 1);
    runPeriod(10, 5);
    trailEdge();
    readReg(4'd11, v); check("R7 count reset", v, 0);
    readReg(4'd1, v);  check("R7 unwell", (v >> 3) & 15, 4'b1101);

    // R8: stall after a full counter range with no edge
    writeReg(4'd0, 32'h0100_0000);
    writeReg(4'd1, 32'h7F);
    writeReg(4'd2, 32'h10);
    repeat (65000) @(negedge clk);
    readReg(4'd1, v); check("R8 no stall yet", (v >> 4) & 1, 0);
    repeat (600) @(negedge clk);
    readReg(4'd1, v); check("R8 stall", (v >> 4) & 1, 1);
    check("R8 irq", int'(irq), 1);
    readReg(4'd8, v); check("R8 no measurement", v, 0);

    done = 1;
    report();
  end
endmodule